// File: doc/BRIEF.md
# Machine-Check Register Bank File

This block holds the error-reporting registers that a processor core exposes for machine-check handling. Software reaches them through a model-specific-register port that carries a 32-bit register index and 64-bit data, with separate read and write strobes. The block decodes the index and applies a write-acceptance rule that depends on the register. It also returns a defined value for every index, including indices that no register claims.

The capability register is a build parameter. Its low byte sets how many error banks respond, clamped to a build maximum, and one of its bits says whether the global control register exists. Each bank takes four consecutive indices starting at a base index. The global status register accepts anything. Control-type registers accept only all-zeros or all-ones. A read returns its data on the cycle after the read strobe.

Top module: `mchk_regfile`

## Requirements
- R1: Reads of the capability index (default 0x179) return CAP_VALUE, and writes to it change no register.
- R2: When capability bit GCTL_BIT (default 8) is clear, reads of the global control index (default 0x17B) return zero and writes to it are ignored.
- R3: When capability bit GCTL_BIT is set, a write to global control is stored only if the data is all-zeros or all-ones; any other value leaves it unchanged.
- R4: A write to the global status index (default 0x17A) is always stored, and a later read returns the stored value.
- R5: Bank registers occupy indices BANK_BASE (default 0x400) up to BANK_BASE + 4*banks - 1, four per bank in the order control, status, address, misc; a read there returns the stored value.
- R6: A bank register whose offset from BANK_BASE is a multiple of four stores only all-zeros or all-ones; the other three registers of a bank store any value.
- R7: A read of any index that no register decodes returns zero.
- R8: Writes to indices past the implemented bank range, or to undecoded indices, are dropped and alter no register.
- R9: The bank count is the low 8 bits of CAP_VALUE clamped to MAX_BANKS (default 10).
- R10: Reset clears global control, global status, every bank register and the read data to zero.
- R11: Read data is registered and appears the cycle after rd_en, holds while rd_en is low, and a read in the same cycle as a write to the same index returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the current index and data |
| rd_en | input | 1 | Read strobe; data returns on the next cycle |
| idx | input | 32 | Register index |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Registered read data |

## Verification
A read and a write can land in the same cycle, and the read path and the write filter then both act on one index. The bench raises both strobes together on a bank address register that already holds a value. It expects the read data to show the old contents, and a later read to show the new value. A second instance has the global control bit clear and a bank count above the maximum. Writes on the shared bus reach both instances, so each write is judged against both configurations.

// File: rtl/mchk_pkg.sv
package mchk_pkg;

    localparam int unsigned DATA_W = 64;
    localparam int unsigned IDX_W  = 32;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CAP,
        SEL_GCTL,
        SEL_GSTAT,
        SEL_BANK
    } sel_e;

    function automatic logic is_all_or_none(input logic [DATA_W-1:0] v);
        return (v == '0) || (v == '1);
    endfunction

endpackage

// File: rtl/mchk_decode.sv
module mchk_decode
    import mchk_pkg::*;
#(
    parameter logic [31:0] IDX_CAP   = 32'h0000_0179,
    parameter logic [31:0] IDX_GSTAT = 32'h0000_017A,
    parameter logic [31:0] IDX_GCTL  = 32'h0000_017B,
    parameter logic [31:0] BANK_BASE = 32'h0000_0400,
    parameter int unsigned MAX_BANKS = 10,
    parameter int unsigned OFF_W     = 6
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       cap_banks,
    input  logic             gctl_present,
    output sel_e             sel,
    output logic [OFF_W-1:0] off
);

    localparam logic [7:0] MAX_B8 = 8'(MAX_BANKS);

    logic [7:0]       nbanks;
    logic [31:0]      limit;
    logic [31:0]      rel;
    logic             in_bank;

    always_comb begin
        nbanks  = (cap_banks > MAX_B8) ? MAX_B8 : cap_banks;
        limit   = {22'd0, nbanks, 2'b00};
        rel     = idx - BANK_BASE;
        in_bank = (idx >= BANK_BASE) && (rel < limit);
        off     = rel[OFF_W-1:0];

        if (idx == IDX_CAP) begin
            sel = SEL_CAP;
        end else if (idx == IDX_GCTL) begin
            sel = gctl_present ? SEL_GCTL : SEL_NONE;
        end else if (idx == IDX_GSTAT) begin
            sel = SEL_GSTAT;
        end else if (in_bank) begin
            sel = SEL_BANK;
        end else begin
            sel = SEL_NONE;
        end
    end

endmodule

// File: rtl/mchk_wfilter.sv
module mchk_wfilter
    import mchk_pkg::*;
(
    input  sel_e              sel,
    input  logic [1:0]        off_lo,
    input  logic [DATA_W-1:0] wdata,
    output logic              accept
);

    logic strict;
    logic writable;

    always_comb begin
        strict   = (sel == SEL_GCTL) || ((sel == SEL_BANK) && (off_lo == 2'b00));
        writable = (sel == SEL_GCTL) || (sel == SEL_GSTAT) || (sel == SEL_BANK);
        accept   = writable && (!strict || is_all_or_none(wdata));
    end

endmodule

// File: rtl/mchk_regfile.sv
module mchk_regfile
    import mchk_pkg::*;
#(
    parameter logic [63:0] CAP_VALUE = 64'h0000_0000_0000_0106,
    parameter int unsigned GCTL_BIT  = 8,
    parameter int unsigned MAX_BANKS = 10,
    parameter logic [31:0] IDX_CAP   = 32'h0000_0179,
    parameter logic [31:0] IDX_GSTAT = 32'h0000_017A,
    parameter logic [31:0] IDX_GCTL  = 32'h0000_017B,
    parameter logic [31:0] BANK_BASE = 32'h0000_0400
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [31:0] idx,
    input  logic [63:0] wdata,
    output logic [63:0] rdata
);

    localparam int unsigned NREG  = 4 * MAX_BANKS;
    localparam int unsigned OFF_W = (NREG > 1) ? $clog2(NREG) : 1;

    typedef struct packed {
        logic [DATA_W-1:0]           gctl;
        logic [DATA_W-1:0]           gstat;
        logic [NREG-1:0][DATA_W-1:0] bank;
        logic [DATA_W-1:0]           rdata;
    } state_t;

    state_t            state_d, state_q;
    sel_e              sel;
    logic [OFF_W-1:0]  off;
    logic              accept;
    logic [DATA_W-1:0] rd_val;

    mchk_decode #(
        .IDX_CAP   (IDX_CAP),
        .IDX_GSTAT (IDX_GSTAT),
        .IDX_GCTL  (IDX_GCTL),
        .BANK_BASE (BANK_BASE),
        .MAX_BANKS (MAX_BANKS),
        .OFF_W     (OFF_W)
    ) u_decode (
        .idx          (idx),
        .cap_banks    (CAP_VALUE[7:0]),
        .gctl_present (CAP_VALUE[GCTL_BIT]),
        .sel          (sel),
        .off          (off)
    );

    mchk_wfilter u_wfilter (
        .sel    (sel),
        .off_lo (off[1:0]),
        .wdata  (wdata),
        .accept (accept)
    );

    // read mux over the current (pre-write) state
    always_comb begin
        case (sel)
            SEL_CAP:   rd_val = CAP_VALUE;
            SEL_GCTL:  rd_val = state_q.gctl;
            SEL_GSTAT: rd_val = state_q.gstat;
            SEL_BANK:  rd_val = state_q.bank[off];
            default:   rd_val = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        if (wr_en && accept) begin
            case (sel)
                SEL_GCTL:  state_d.gctl      = wdata;
                SEL_GSTAT: state_d.gstat     = wdata;
                SEL_BANK:  state_d.bank[off] = wdata;
                default:   state_d.gstat     = state_q.gstat;
            endcase
        end
        if (rd_en) begin
            state_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata = state_q.rdata;

endmodule

// File: rtl/mchk_regfile_chk.sv
module mchk_regfile_chk #(
    parameter logic [63:0] CAP_VALUE = 64'h0000_0000_0000_0106,
    parameter int unsigned GCTL_BIT  = 8,
    parameter int unsigned MAX_BANKS = 10,
    parameter logic [31:0] IDX_CAP   = 32'h0000_0179,
    parameter logic [31:0] IDX_GSTAT = 32'h0000_017A,
    parameter logic [31:0] IDX_GCTL  = 32'h0000_017B,
    parameter logic [31:0] BANK_BASE = 32'h0000_0400
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [31:0] idx,
    input logic [63:0] wdata,
    input logic [63:0] rdata,
    input logic [63:0] gctl_q,
    input logic [63:0] gstat_q
);

    localparam int unsigned CAP_B   = int'(CAP_VALUE[7:0]);
    localparam int unsigned EFF_B   = (CAP_B > MAX_BANKS) ? MAX_BANKS : CAP_B;
    localparam logic [31:0] BANK_END = BANK_BASE + 32'(4 * EFF_B);
    localparam logic        HAS_GCTL = CAP_VALUE[GCTL_BIT];

    logic unmapped;
    logic full_word;

    always_comb begin
        unmapped = (idx != IDX_CAP) && (idx != IDX_GSTAT)
                   && !((idx == IDX_GCTL) && HAS_GCTL)
                   && !((idx >= BANK_BASE) && (idx < BANK_END));
        full_word = (wdata == '0) || (wdata == '1);
    end

    AST_CAP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && idx == IDX_CAP) |=> (rdata == CAP_VALUE)); // R1

    AST_GCTL_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && idx == IDX_GCTL && !HAS_GCTL) |=> (rdata == '0)); // R2

    AST_GCTL_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_GCTL && !full_word) |=> $stable(gctl_q)); // R3

    AST_GSTAT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_GSTAT) |=> (gstat_q == $past(wdata))); // R4

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && unmapped) |=> (rdata == '0)); // R7

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R11

endmodule

bind mchk_regfile mchk_regfile_chk #(
    .CAP_VALUE (CAP_VALUE),
    .GCTL_BIT  (GCTL_BIT),
    .MAX_BANKS (MAX_BANKS),
    .IDX_CAP   (IDX_CAP),
    .IDX_GSTAT (IDX_GSTAT),
    .IDX_GCTL  (IDX_GCTL),
    .BANK_BASE (BANK_BASE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .idx     (idx),
    .wdata   (wdata),
    .rdata   (rdata),
    .gctl_q  (state_q.gctl),
    .gstat_q (state_q.gstat)
);

// File: tb/mchk_regfile_tb.sv
module mchk_regfile_tb;

    localparam logic [31:0] I_CAP   = 32'h179;
    localparam logic [31:0] I_GSTAT = 32'h17A;
    localparam logic [31:0] I_GCTL  = 32'h17B;
    localparam logic [31:0] BASE    = 32'h400;
    localparam logic [63:0] ONES    = '1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] idx = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata_a, rdata_b;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    // 6 banks, global control present
    mchk_regfile #(.CAP_VALUE(64'h0000_0000_0000_0106)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .idx(idx), .wdata(wdata), .rdata(rdata_a));

    // 12 banks requested (clamped to 10), global control absent
    mchk_regfile #(.CAP_VALUE(64'h0000_0000_0000_000C)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .idx(idx), .wdata(wdata), .rdata(rdata_b));

    typedef struct packed {
        logic        is_rd;
        logic [31:0] ix;
        logic [63:0] val;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 32'h400, 64'hFFFF_FFFF_FFFF_FFFF, 8'd6},  // R6 ctl all ones
        '{1'b1, 32'h400, 64'hFFFF_FFFF_FFFF_FFFF, 8'd6},
        '{1'b0, 32'h400, 64'h5,                   8'd6},  // R6 rejected
        '{1'b1, 32'h400, 64'hFFFF_FFFF_FFFF_FFFF, 8'd6},
        '{1'b0, 32'h401, 64'hDEAD,                8'd6},  // R6 status free
        '{1'b1, 32'h401, 64'hDEAD,                8'd6},
        '{1'b0, 32'h402, 64'h1234,                8'd5},  // R5 address
        '{1'b1, 32'h402, 64'h1234,                8'd5},
        '{1'b0, 32'h403, 64'h77,                  8'd5},  // R5 misc
        '{1'b1, 32'h403, 64'h77,                  8'd5},
        '{1'b0, 32'h417, 64'hABC,                 8'd5},  // R5 last reg bank 5
        '{1'b1, 32'h417, 64'hABC,                 8'd5},
        '{1'b0, 32'h418, 64'h99,                  8'd8},  // R8 past range
        '{1'b1, 32'h418, 64'h0,                   8'd8},
        '{1'b0, 32'h17A, 64'h5555_0000_1111,      8'd4},  // R4
        '{1'b1, 32'h17A, 64'h5555_0000_1111,      8'd4},
        '{1'b0, 32'h17B, 64'h3,                   8'd3},  // R3 rejected
        '{1'b1, 32'h17B, 64'h0,                   8'd3},
        '{1'b0, 32'h17B, 64'hFFFF_FFFF_FFFF_FFFF, 8'd3},  // R3 accepted
        '{1'b1, 32'h17B, 64'hFFFF_FFFF_FFFF_FFFF, 8'd3},
        '{1'b0, 32'h179, 64'h0,                   8'd1},  // R1 write ignored
        '{1'b1, 32'h179, 64'h106,                 8'd1}
    };

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] i, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; idx = i; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [31:0] i, input logic [63:0] exp, input bit use_b,
                      input string req);
        @(negedge clk);
        rd_en = 1'b1; idx = i;
        @(negedge clk);
        rd_en = 1'b0;
        check(use_b ? rdata_b : rdata_a, exp, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rdata_a, 64'h0, "R10 rdata in reset");
        rst_n = 1'b1;
        rd(I_GSTAT, 64'h0, 1'b0, "R10 gstat after reset");
        rd(I_GCTL,  64'h0, 1'b0, "R10 gctl after reset");

        for (int k = 0; k < NV; k++) begin
            if (VEC[k].is_rd)
                rd(VEC[k].ix, VEC[k].val, 1'b0, $sformatf("R%0d vector %0d", VEC[k].req, k));
            else
                wr(VEC[k].ix, VEC[k].val);
        end

        // R7: undecoded reads
        rd(32'h500, 64'h0, 1'b0, "R7 undecoded index");
        rd(32'h3FF, 64'h0, 1'b0, "R7 below bank base");

        // R2: second instance has no global control; all-ones was written above
        rd(I_GCTL, 64'h0, 1'b1, "R2 gctl absent read");
        rd(I_CAP, 64'h0C, 1'b1, "R1 capability second config");

        // R9: clamp to 10 banks in second instance
        wr(BASE + 32'd39, 64'hC0FFEE);
        rd(BASE + 32'd39, 64'hC0FFEE, 1'b1, "R9 last clamped register");
        wr(BASE + 32'd40, 64'hBAD);
        rd(BASE + 32'd40, 64'h0, 1'b1, "R9 beyond clamp");
        rd(BASE + 32'd39, 64'h0, 1'b0, "R8 beyond six banks");
        rd(BASE + 32'd24, 64'h0, 1'b1, "R8 store bank 6 untouched by drop");

        // R11: read and write together on the same index
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; idx = 32'h402; wdata = 64'hBEEF;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check(rdata_a, 64'h1234, "R11 same-cycle read sees old value");
        repeat (2) @(negedge clk);
        check(rdata_a, 64'h1234, "R11 rdata holds while idle");
        rd(32'h402, 64'hBEEF, 1'b0, "R11 write landed");

        // R10: second reset clears stored state
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(rdata_a, 64'h0, "R10 rdata cleared");
        rst_n = 1'b1;
        rd(32'h401, 64'h0, 1'b0, "R10 bank cleared");
        rd(I_GSTAT, 64'h0, 1'b0, "R10 gstat cleared");
        rd(I_GCTL, 64'h0, 1'b0, "R10 gctl cleared");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule